// File: doc/BRIEF.md
# Multicycle Functional Unit Issue Interlock

This block is the decode-stage issue gate of an in-order, single-issue pipeline whose execute side has an integer ALU, a data-memory path, a pipelined floating-point adder, a pipelined multiplier and a non-pipelined divider. Each cycle it looks at the instruction held in decode: its unit class, its destination register and up to two source registers. It then decides whether that instruction may leave decode in this cycle or must wait.

An instruction is held when any of four conditions is true. A source is still being produced by an older instruction (read-after-write). The divider is still occupied by an earlier divide. The instruction would reach the single memory/write-back slot in the same cycle as an older one. Its destination would be written no later than an older write to the same register that is still in flight (write-after-write). Write-after-read cannot arise, because operands are read in order in decode.

The block keeps three pieces of state. A per-register countdown records the cycles left before each register's value can be forwarded. A shift register of future write-back slots records which slots are already claimed. A down-counter tracks how long the divider stays occupied. The arithmetic itself is outside this block. Issue timing is counted from the decode cycle in which `issue` is high.

Top module: `iss_interlock`

## Requirements
- R1: Reset (active-low, synchronous) clears all pending counts, slot reservations and divider occupancy. After reset, a valid instruction with no hazard issues in its first cycle. When `dec_valid` is low, both `stall` and `issue` are low.
- R2: The unit codes on `dec_unit` and their result latencies are: 0 integer ALU, latency 0; 1 data memory, latency 1; 2 float add, latency 3; 3 multiply, latency 6; 4 divide, latency 24. Codes 5 to 7 behave as the integer ALU.
- R3: A valid instruction with an enabled source register stalls while that register's producer has a nonzero remaining latency. After a producer of latency L issues, a consumer of its result issues no earlier than L+1 cycles later. This means exactly L stall cycles when nothing else interferes.
- R4: A divide cannot issue until 25 cycles have passed since the previous divide issued. During that window, a divide stalls for 24 cycles.
- R5: No two issued instructions reach write-back in the same cycle, where write-back is the issue cycle plus the unit latency. The younger instruction stalls, even when it has no data dependency.
- R6: An instruction that writes a register stalls while an older in-flight write to that register would complete in the same cycle as the new write or later. A younger write with a longer latency than the remaining count of the older one is not stalled.
- R7: Disabled fields have no effect. A source whose enable is low does not cause a read-after-write stall, and a destination whose write enable is low does not cause a write-after-write stall. `issue` is high exactly when `dec_valid` is high and `stall` is low.
- R8: The adder and multiplier are pipelined. Two independent multiplies on consecutive cycles both issue without stalling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_unit | input | 3 | Unit class of the decode instruction (R2 codes) |
| dec_dst | input | 5 | Destination register index |
| dec_dst_we | input | 1 | Instruction writes its destination |
| dec_src_a | input | 5 | First source register index |
| dec_src_a_en | input | 1 | First source is read |
| dec_src_b | input | 5 | Second source register index |
| dec_src_b_en | input | 1 | Second source is read |
| stall | output | 1 | Decode instruction is held this cycle |
| issue | output | 1 | Decode instruction leaves decode this cycle |

## Verification
The gate is driven with sequences that each isolate a single cause of holding:
- A load followed by its consumer, and a multiply followed by its consumer. These separate the 1-cycle and 6-cycle wait lengths.
- An independent load placed where its write-back meets an earlier add. This shows a port conflict stalling with no data dependency.
- A short write behind a long write to the same register, and the reverse order. This tells a write-after-write stall apart from a harmless out-of-order pair.
- A held divide counted cycle by cycle, which pins the 25-cycle initiation interval.
- Disabled fields, back-to-back multiplies, spare unit codes and a mid-flight reset. These confirm that nothing else blocks issue.

// File: rtl/iss_interlock_pkg.sv
// Package: shared unit-class encoding for the issue interlock.
// Assumes the decode stage presents one of these codes on dec_unit.
package iss_interlock_pkg;

    typedef enum logic [2:0] {
        FU_ALU  = 3'd0,
        FU_MEM  = 3'd1,
        FU_FADD = 3'd2,
        FU_FMUL = 3'd3,
        FU_FDIV = 3'd4
    } fu_e;

    // Larger of two integers, used to size the slot ring.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/reg_pend_table.sv
// Module: per-register countdown of cycles until a result can be forwarded.
// Assumes at most one load per cycle; a load overrides the current count,
// which is safe because the WAW check keeps newer writes finishing later.
module reg_pend_table #(
    parameter int NREG = 32,
    parameter int CW   = 5,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] load_idx,
    input  logic [CW-1:0] load_val,
    input  logic [RW-1:0] rd_a_idx,
    input  logic [RW-1:0] rd_b_idx,
    input  logic [RW-1:0] rd_w_idx,
    output logic [CW-1:0] cnt_a,
    output logic [CW-1:0] cnt_b,
    output logic [CW-1:0] cnt_w
);

    logic [CW-1:0] cnt_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load on issue of a writer, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (load && (load_idx == RW'(g))) begin
                cnt_q[g] <= load_val;
            end else if (cnt_q[g] != '0) begin
                cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end
    end

    // Read ports for the two sources and the destination.
    always_comb begin
        cnt_a = cnt_q[rd_a_idx];
        cnt_b = cnt_q[rd_b_idx];
        cnt_w = cnt_q[rd_w_idx];
    end

endmodule

// File: rtl/wb_slot_ring.sv
// Module: reservation shift register for the single write-back slot.
// Bit k set means the slot k cycles after the current issue cycle is taken.
// Assumes claim_pos and query_pos are below DEPTH.
module wb_slot_ring #(
    parameter int DEPTH = 25,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim,
    input  logic [CW-1:0] claim_pos,
    input  logic [CW-1:0] query_pos,
    output logic          taken
);

    logic [DEPTH-1:0] slot_q;
    logic [DEPTH-1:0] slot_mark;

    // Merge this cycle's claim into the reservation vector.
    always_comb begin
        slot_mark = slot_q;
        if (claim) slot_mark[claim_pos] = 1'b1;
    end

    // Advance the reservations by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_mark >> 1;
    end

    // Report whether the queried future slot is already claimed.
    always_comb taken = slot_q[query_pos];

endmodule

// File: rtl/div_occupancy.sv
// Module: busy down-counter for the non-pipelined divider.
// Loaded with II-1 when a divide issues; the divider is free at zero.
module div_occupancy #(
    parameter int II = 25,
    localparam int DW = $clog2(II + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [DW-1:0] left_q;

    // Reload on a divide issue, else count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= DW'(II - 1);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    // Busy whenever cycles of the initiation interval remain.
    always_comb busy = (left_q != '0);

endmodule

// File: rtl/iss_interlock.sv
// Module: decode issue gate for an in-order single-issue pipeline with
// multicycle units. Holds the decode instruction on RAW, divider busy,
// write-back slot conflict or WAW; otherwise issues it. Assumes the
// decode stage keeps the held instruction stable while stall is high.
module iss_interlock
    import iss_interlock_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_ALU = 0,
    parameter int LAT_MEM = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 6,
    parameter int LAT_DIV = 24,
    parameter int DIV_II  = 25,
    localparam int RW     = $clog2(NREG),
    localparam int MAXL   = imax(imax(imax(LAT_ALU, LAT_MEM), imax(LAT_ADD, LAT_MUL)), LAT_DIV),
    localparam int CW     = $clog2(MAXL + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [2:0]    dec_unit,
    input  logic [RW-1:0] dec_dst,
    input  logic          dec_dst_we,
    input  logic [RW-1:0] dec_src_a,
    input  logic          dec_src_a_en,
    input  logic [RW-1:0] dec_src_b,
    input  logic          dec_src_b_en,
    output logic          stall,
    output logic          issue
);

    logic [CW-1:0] lat;
    logic          is_div;
    logic [CW-1:0] pend_a, pend_b, pend_w;
    logic          slot_taken;
    logic          div_busy;
    logic          hz_raw, hz_waw, hz_struct, hz_port, hz_any;

    // Map the unit class to its result latency.
    always_comb begin
        is_div = 1'b0;
        case (fu_e'(dec_unit))
            FU_MEM:  lat = CW'(LAT_MEM);
            FU_FADD: lat = CW'(LAT_ADD);
            FU_FMUL: lat = CW'(LAT_MUL);
            FU_FDIV: begin
                lat    = CW'(LAT_DIV);
                is_div = 1'b1;
            end
            default: lat = CW'(LAT_ALU);
        endcase
    end

    reg_pend_table #(.NREG(NREG), .CW(CW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue && dec_dst_we),
        .load_idx (dec_dst),
        .load_val (lat),
        .rd_a_idx (dec_src_a),
        .rd_b_idx (dec_src_b),
        .rd_w_idx (dec_dst),
        .cnt_a    (pend_a),
        .cnt_b    (pend_b),
        .cnt_w    (pend_w)
    );

    wb_slot_ring #(.DEPTH(MAXL + 1), .CW(CW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (issue),
        .claim_pos (lat),
        .query_pos (lat),
        .taken     (slot_taken)
    );

    div_occupancy #(.II(DIV_II)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && is_div),
        .busy  (div_busy)
    );

    // Combine the four hazard classes into the stall and issue decision.
    always_comb begin
        hz_raw    = (dec_src_a_en && (pend_a != '0)) ||
                    (dec_src_b_en && (pend_b != '0));
        hz_waw    = dec_dst_we && (pend_w > lat);
        hz_struct = is_div && div_busy;
        hz_port   = slot_taken;
        hz_any    = hz_raw || hz_waw || hz_struct || hz_port;
        stall     = dec_valid && hz_any;
        issue     = dec_valid && !hz_any;
    end

endmodule

// File: rtl/iss_interlock_chk.sv
// Module: temporal checks on the issue gate, bound to iss_interlock.
// Assumes default unit latencies (memory one more than ALU, divide II > 1).
module iss_interlock_chk
    import iss_interlock_pkg::*;
#(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    dec_unit,
    input logic [RW-1:0] dec_dst,
    input logic          dec_dst_we,
    input logic [RW-1:0] dec_src_a,
    input logic          dec_src_a_en,
    input logic          issue
);

    AST_DIV_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == FU_FDIV) |=> !(issue && dec_unit == FU_FDIV)); // R4

    AST_MUL_CONSUMER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == FU_FMUL && dec_dst_we)
        |=> !(issue && dec_src_a_en && dec_src_a == $past(dec_dst))); // R3

    AST_WB_SLOT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == FU_MEM) |=> !(issue && dec_unit == FU_ALU)); // R5

    AST_WAW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == FU_FDIV && dec_dst_we)
        |=> !(issue && dec_unit == FU_ALU && dec_dst_we && dec_dst == $past(dec_dst))); // R6

endmodule

bind iss_interlock iss_interlock_chk #(.RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_unit     (dec_unit),
    .dec_dst      (dec_dst),
    .dec_dst_we   (dec_dst_we),
    .dec_src_a    (dec_src_a),
    .dec_src_a_en (dec_src_a_en),
    .issue        (issue)
);

// File: tb/sim_iss_interlock.sv
// Bench: a vector table walked one cycle per entry, then directed tests.
module sim_iss_interlock;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid;
    logic [2:0] dec_unit;
    logic [4:0] dec_dst, dec_src_a, dec_src_b;
    logic       dec_dst_we, dec_src_a_en, dec_src_b_en;
    logic       stall, issue;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    iss_interlock u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .dec_dst(dec_dst), .dec_dst_we(dec_dst_we),
        .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
        .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
        .stall(stall), .issue(issue)
    );

    // {valid, unit, dst, we, src_a, en_a, src_b, en_b, expected stall}
    localparam int NV = 25;
    localparam logic [22:0] VECS [0:NV-1] = '{
        {1'b1,3'd0,5'd1 ,1'b1,5'd2,1'b1,5'd3,1'b1,1'b0},  // 0  ALU r1
        {1'b1,3'd0,5'd4 ,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0},  // 1  ALU uses r1, no wait
        {1'b1,3'd1,5'd5 ,1'b1,5'd4,1'b1,5'd0,1'b0,1'b0},  // 2  load r5
        {1'b1,3'd0,5'd6 ,1'b1,5'd5,1'b1,5'd0,1'b0,1'b1},  // 3  load-use stall
        {1'b1,3'd0,5'd6 ,1'b1,5'd5,1'b1,5'd0,1'b0,1'b0},  // 4  issues
        {1'b1,3'd3,5'd7 ,1'b1,5'd1,1'b1,5'd4,1'b1,1'b0},  // 5  MUL r7
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 6  wait 1
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 7
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 8
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 9
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 10
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b1},  // 11 wait 6
        {1'b1,3'd0,5'd8 ,1'b1,5'd7,1'b1,5'd0,1'b0,1'b0},  // 12 issues
        {1'b1,3'd2,5'd9 ,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0},  // 13 ADD r9
        {1'b0,3'd0,5'd0 ,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0},  // 14 bubble
        {1'b1,3'd1,5'd10,1'b1,5'd2,1'b1,5'd0,1'b0,1'b1},  // 15 load meets ADD slot
        {1'b1,3'd1,5'd10,1'b1,5'd2,1'b1,5'd0,1'b0,1'b0},  // 16 issues
        {1'b1,3'd2,5'd11,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0},  // 17 ADD r11
        {1'b1,3'd0,5'd11,1'b1,5'd2,1'b1,5'd0,1'b0,1'b1},  // 18 WAW
        {1'b1,3'd0,5'd11,1'b1,5'd2,1'b1,5'd0,1'b0,1'b1},  // 19 WAW
        {1'b1,3'd0,5'd11,1'b1,5'd2,1'b1,5'd0,1'b0,1'b1},  // 20 WAW + slot
        {1'b1,3'd0,5'd11,1'b1,5'd2,1'b1,5'd0,1'b0,1'b0},  // 21 issues
        {1'b1,3'd3,5'd12,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0},  // 22 MUL r12
        {1'b1,3'd4,5'd12,1'b1,5'd2,1'b1,5'd0,1'b0,1'b0},  // 23 DIV r12, later: ok
        {1'b1,3'd4,5'd13,1'b1,5'd2,1'b1,5'd0,1'b0,1'b1}   // 24 second DIV busy
    };

    function automatic string vec_req(input int i);
        if (i <= 1)  return "R3";
        if (i <= 4)  return "R2 R3";
        if (i <= 12) return "R3";
        if (i <= 16) return "R5";
        if (i <= 23) return "R6";
        return "R4";
    endfunction

    task automatic drive(input logic v, input logic [2:0] u, input logic [4:0] d,
                         input logic we, input logic [4:0] sa, input logic sae,
                         input logic [4:0] sb, input logic sbe);
        dec_valid = v; dec_unit = u; dec_dst = d; dec_dst_we = we;
        dec_src_a = sa; dec_src_a_en = sae; dec_src_b = sb; dec_src_b_en = sbe;
    endtask

    task automatic check(input string req, input logic exp_stall);
        logic exp_issue;
        exp_issue = dec_valid && !exp_stall;
        n_chk++;
        if (stall !== exp_stall || issue !== exp_issue) begin
            n_fail++;
            $display("FAIL %s: stall/issue=%b%b expected %b%b", req,
                     stall, issue, exp_stall, exp_issue);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cycles=5000 expected completion earlier");
        finish_run();
    end

    initial begin
        int waits;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5 check("R1 idle after reset", 1'b0);

        // Table walk: one entry per cycle, driven at negedge, sampled 5 ns later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i][22], VECS[i][21:19], VECS[i][18:14], VECS[i][13],
                  VECS[i][12:8], VECS[i][7], VECS[i][6:2], VECS[i][1]);
            #5 check(vec_req(i), VECS[i][0]);
        end

        // R4: hold the second divide; 23 more stall cycles, then issue.
        waits = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            #5;
            if (!stall) break;
            waits++;
        end
        n_chk++;
        if (waits != 23) begin
            n_fail++;
            $display("FAIL R4: extra divide stalls=%0d expected 23", waits);
        end
        check("R4 divide issues after interval", 1'b0);

        // R3: consumer of the divide result waits.
        @(negedge clk);
        drive(1, 0, 5'd14, 1, 5'd13, 1, 0, 0);
        #5 check("R3 divide consumer", 1'b1);

        // R1: reset mid-flight clears pending state.
        @(negedge clk);
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5 check("R1 valid low after reset", 1'b0);
        @(negedge clk);
        drive(1, 0, 5'd14, 1, 5'd13, 1, 0, 0);
        #5 check("R1 pending cleared", 1'b0);

        // R2: unused code 7 acts as ALU and meets a load's slot.
        @(negedge clk);
        drive(1, 1, 5'd21, 1, 0, 0, 0, 0);
        #5 check("R2 load", 1'b0);
        @(negedge clk);
        drive(1, 7, 5'd22, 1, 0, 0, 0, 0);
        #5 check("R2 code 7 latency 0 slot clash", 1'b1);
        @(negedge clk);
        #5 check("R2 code 7 issues", 1'b0);

        // R7: disabled source and disabled write ignore a pending register.
        @(negedge clk);
        drive(1, 3, 5'd23, 1, 0, 0, 0, 0);
        #5 check("R7 mul r23", 1'b0);
        @(negedge clk);
        drive(1, 0, 5'd24, 1, 5'd23, 0, 0, 0);
        #5 check("R7 disabled source", 1'b0);
        @(negedge clk);
        drive(1, 0, 5'd23, 0, 0, 0, 0, 0);
        #5 check("R7 disabled write", 1'b0);

        // R8: back-to-back independent multiplies.
        @(negedge clk);
        drive(1, 3, 5'd25, 1, 0, 0, 0, 0);
        #5 check("R8 first mul", 1'b0);
        @(negedge clk);
        drive(1, 3, 5'd26, 1, 0, 0, 0, 0);
        #5 check("R8 second mul", 1'b0);

        // R7: no valid instruction means no stall.
        @(negedge clk);
        drive(0, 3, 5'd25, 1, 5'd26, 1, 0, 0);
        #5 check("R7 invalid", 1'b0);

        finish_run();
    end

endmodule